// File: doc/BRIEF.md
# Command Queue Frontend for Interrupt Translation

This block drains a software-filled ring of commands that lives in a small local memory. Each command slot is 32 bytes, made up of four 64-bit little-endian words. Software fills slots through a memory write port. It programs a base register that carries a valid bit and the ring length, turns the unit on through a control register, and advances a write offset. The block then takes the command at its read offset and checks its opcode. It presents the command to a downstream executor over a valid/ready handshake and waits for the executor to report that the command is finished. Only after that report does it step the read offset, wrapping at the end of the ring.

A retirement that reports failure, or an opcode the block does not accept, freezes the queue. The stalled flag rises and the read offset stays on the offending slot. The queue stays frozen until software turns the unit off and back on. The empty flag shows when the two offsets match. The quiescent flag shows when no command is in flight. Memory attribute fields in the base register are kept for readback and play no part in processing.

Top module: `cmdq_frontend`

## Requirements
- R1: After reset: rd_off is 0, stalled is 0, quiescent is 1, empty is 1, cmd_valid is 0 and base_rd is 0.
- R2: Commands are fetched only while the enable bit (control register bit 0) is 1 and the base register valid bit (bit 63) is 1. Otherwise cmd_valid stays 0 even when the queue holds commands.
- R3: The command at slot s is memory words s*4+0 to s*4+3, with word k on cmd_data[64k+63:64k]. cmd_valid stays high and cmd_data stays stable until cmd_ready is sampled high, and cmd_valid then drops.
- R4: The read offset advances by 32 only on a cycle where ret_valid=1 and ret_ok=1 follows an accepted command. It holds while the executor has not yet retired.
- R5: The ring length is (base[7:0]+1)*4096 bytes, limited to the local memory. For size 0, the offset goes from 0xFE0 to 0.
- R6: empty is 1 exactly when the write offset equals the read offset. No command is fetched while the queue is empty.
- R7: A retirement with ret_ok=0 sets stalled and leaves the read offset on the failed command.
- R8: The opcode is word 0 bits [7:0]. Only values 0x01 to 0x0F are accepted. Any other value sets stalled without raising cmd_valid and keeps the read offset.
- R9: While stalled, writes to the write offset do not restart processing. stalled clears only when enable is written 1 while it is 0. The same command is then fetched again.
- R10: quiescent is 1 exactly when no command is between fetch and retirement, and cmd_valid is never high while it is 1.
- R11: Register select 0 is control, 1 is base and 2 is write offset. Offsets are in bytes; write-offset bits [4:0] are dropped and rd_off[4:0] reads 0. base_rd returns the last base value written, including attribute bits [61:56] and [11:10], which do not affect processing.
- R12: A write to the base register sets the read offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 write offset |
| cfg_wdata | input | 64 | Register write data |
| mem_we | input | 1 | Ring memory write strobe |
| mem_addr | input | 10 | Ring memory 64-bit word index |
| mem_wdata | input | 64 | Ring memory write data |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_data | output | 256 | Four command words, word 0 lowest |
| ret_valid | input | 1 | Executor finished the accepted command |
| ret_ok | input | 1 | Finished command succeeded |
| rd_off | output | 13 | Read offset in bytes |
| stalled | output | 1 | Queue frozen by a failed or rejected command |
| quiescent | output | 1 | No command in flight |
| empty | output | 1 | Read and write offsets are equal |
| base_rd | output | 64 | Readback of the base register |

## Verification
A retirement and a write-offset update can land on the same clock edge. In that cycle one register moves the read pointer while another moves the write pointer, and the next fetch decision depends on both. The bench drives ret_valid and a write-offset write in the same cycle. After a successful retirement it expects the read offset to have advanced and the newly published command to be issued next. After a failed retirement it expects the stall to win: the read offset stays put, and no command is issued despite the fresh write offset. The same scenarios are also reached from randomly sized batches with random low offset bits and random handshake delays. Expected values come from a bench-side ring model.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int WORD_W     = 64;
    localparam int CMD_WORDS  = 4;
    localparam int WSEL_W     = $clog2(CMD_WORDS);
    localparam int CMD_W      = WORD_W * CMD_WORDS;
    localparam int GRAN_LSB   = 5;
    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_SLOTS = PAGE_BYTES >> GRAN_LSB;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_WOFF = 2'd2;

    localparam int BASE_VALID_BIT = 63;
    localparam int SIZE_W         = 8;

    localparam logic [7:0] OPC_FIRST = 8'h01;
    localparam logic [7:0] OPC_LAST  = 8'h0F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    function automatic logic opcode_ok(input logic [7:0] op);
        return (op >= OPC_FIRST) && (op <= OPC_LAST);
    endfunction
endpackage

// File: rtl/cq_regs.sv
module cq_regs
    import cq_pkg::*;
#(
    parameter int MEM_SLOTS = 256,
    parameter int SLOT_W    = 8,
    parameter int LEN_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [63:0]       cfg_wdata,
    output logic              en,
    output logic              base_valid,
    output logic [LEN_W-1:0]  len_slots,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [63:0]       base_word,
    output logic              en_rise,
    output logic              base_wr
);
    typedef struct packed {
        logic              en;
        logic [63:0]       base;
        logic [SLOT_W-1:0] wr;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [31:0] raw_len;

    always_comb begin
        regs_d  = regs_q;
        en_rise = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0] && !regs_q.en;
        base_wr = cfg_we && (cfg_sel == SEL_BASE);
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: regs_d.en   = cfg_wdata[0];
                SEL_BASE: regs_d.base = cfg_wdata;
                SEL_WOFF: regs_d.wr   = cfg_wdata[GRAN_LSB +: SLOT_W];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        raw_len   = (32'(regs_q.base[SIZE_W-1:0]) + 32'd1) * 32'(PAGE_SLOTS);
        len_slots = (raw_len > 32'(MEM_SLOTS)) ? LEN_W'(MEM_SLOTS) : raw_len[LEN_W-1:0];
    end

    assign en         = regs_q.en;
    assign base_valid = regs_q.base[BASE_VALID_BIT];
    assign wr_slot    = regs_q.wr;
    assign base_word  = regs_q.base;

    // R9: an enable rise leaves the unit enabled
    a_r9_rise_enables: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> en);
    // R11: base contents move only on a base write
    a_r11_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> $stable(base_word));
endmodule

// File: rtl/cq_ring_mem.sv
module cq_ring_mem
    import cq_pkg::*;
#(
    parameter int MEM_SLOTS = 256,
    parameter int SLOT_W    = 8
) (
    input  logic                     clk,
    input  logic                     mem_we,
    input  logic [SLOT_W+WSEL_W-1:0] mem_addr,
    input  logic [WORD_W-1:0]        mem_wdata,
    input  logic [SLOT_W-1:0]        rd_slot,
    output logic [CMD_W-1:0]         rd_data
);
    localparam int MEM_WORDS = MEM_SLOTS * CMD_WORDS;

    logic [WORD_W-1:0] mem_q [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_addr] <= mem_wdata;
    end

    for (genvar k = 0; k < CMD_WORDS; k++) begin : g_word
        assign rd_data[k*WORD_W +: WORD_W] = mem_q[{rd_slot, WSEL_W'(k)}];
    end
endmodule

// File: rtl/cq_seq.sv
module cq_seq
    import cq_pkg::*;
#(
    parameter int SLOT_W = 8,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              base_valid,
    input  logic [LEN_W-1:0]  len_slots,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              en_rise,
    input  logic              base_wr,
    input  logic [CMD_W-1:0]  mem_data,
    input  logic              cmd_ready,
    input  logic              ret_valid,
    input  logic              ret_ok,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              stalled,
    output logic              quiescent,
    output logic              empty
);
    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] rd;
        logic              stall;
        logic [CMD_W-1:0]  cmd;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [LEN_W-1:0] rd_inc;

    assign empty  = (seq_q.rd == wr_slot);
    assign rd_inc = {1'b0, seq_q.rd} + LEN_W'(1);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (en && base_valid && !seq_q.stall && !empty)
                    seq_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                if (opcode_ok(mem_data[7:0])) begin
                    seq_d.cmd   = mem_data;
                    seq_d.state = ST_ISSUE;
                end else begin
                    seq_d.stall = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (ret_valid) begin
                    if (ret_ok) seq_d.rd = (rd_inc == len_slots) ? '0 : rd_inc[SLOT_W-1:0];
                    else        seq_d.stall = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
        if (en_rise) seq_d.stall = 1'b0;
        if (base_wr) seq_d.rd    = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rd_slot   = seq_q.rd;
    assign cmd_valid = (seq_q.state == ST_ISSUE);
    assign cmd_data  = seq_q.cmd;
    assign stalled   = seq_q.stall;
    assign quiescent = (seq_q.state == ST_IDLE);

    // R3: offered command holds until taken
    a_r3_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
    // R4: pointer moves only on a good retirement or a base write
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && ret_ok) && !base_wr |=> $stable(rd_slot));
    // R7: a stall persists until the unit is re-enabled
    a_r7_stall_keep: assert property (@(posedge clk) disable iff (!rst_n)
        stalled && !en_rise |=> stalled);
    // R9: nothing offered while stalled
    a_r9_no_offer_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !cmd_valid);
    // R6: empty queue is never fetched
    a_r6_no_fetch_empty: assert property (@(posedge clk) disable iff (!rst_n)
        quiescent && empty |=> seq_q.state != ST_FETCH);
    // R10: quiescent excludes an offered command
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        quiescent |-> !cmd_valid);
endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend
    import cq_pkg::*;
#(
    parameter int  MEM_SLOTS = 256,
    localparam int SLOT_W    = $clog2(MEM_SLOTS),
    localparam int OFF_W     = SLOT_W + GRAN_LSB,
    localparam int MEM_AW    = SLOT_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [63:0]       cfg_wdata,
    input  logic              mem_we,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_wdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              ret_valid,
    input  logic              ret_ok,
    output logic [OFF_W-1:0]  rd_off,
    output logic              stalled,
    output logic              quiescent,
    output logic              empty,
    output logic [63:0]       base_rd
);
    localparam int LEN_W = SLOT_W + 1;

    logic              en, base_valid, en_rise, base_wr;
    logic [LEN_W-1:0]  len_slots;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [CMD_W-1:0]  mem_data;

    cq_regs #(.MEM_SLOTS(MEM_SLOTS), .SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .en(en), .base_valid(base_valid), .len_slots(len_slots), .wr_slot(wr_slot),
        .base_word(base_rd), .en_rise(en_rise), .base_wr(base_wr)
    );

    cq_ring_mem #(.MEM_SLOTS(MEM_SLOTS), .SLOT_W(SLOT_W)) u_mem (
        .clk(clk), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_slot(rd_slot), .rd_data(mem_data)
    );

    cq_seq #(.SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .base_valid(base_valid), .len_slots(len_slots),
        .wr_slot(wr_slot), .en_rise(en_rise), .base_wr(base_wr), .mem_data(mem_data),
        .cmd_ready(cmd_ready), .ret_valid(ret_valid), .ret_ok(ret_ok), .rd_slot(rd_slot),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .stalled(stalled),
        .quiescent(quiescent), .empty(empty)
    );

    assign rd_off = {rd_slot, {GRAN_LSB{1'b0}}};
endmodule

// File: tb/cmdq_frontend_tb_top.sv
module cmdq_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RING       = 128;
    localparam logic [63:0] BASEV = 64'h8000_0000_0000_0000 | (64'h2A << 56) | (64'h3 << 10);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         cfg_we = 0;
    logic [1:0]   cfg_sel = 0;
    logic [63:0]  cfg_wdata = 0;
    logic         mem_we = 0;
    logic [9:0]   mem_addr = 0;
    logic [63:0]  mem_wdata = 0;
    logic         cmd_valid, cmd_ready = 0;
    logic [255:0] cmd_data;
    logic         ret_valid = 0, ret_ok = 0;
    logic [12:0]  rd_off;
    logic         stalled, quiescent, empty;
    logic [63:0]  base_rd;

    cmdq_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .ret_valid(ret_valid), .ret_ok(ret_ok), .rd_off(rd_off), .stalled(stalled),
        .quiescent(quiescent), .empty(empty), .base_rd(base_rd)
    );

    logic [63:0] bm [1024];
    int total = 0, bad = 0;
    int exp_rd = 0, exp_wr = 0, served = 0;
    bit exp_stall = 0;
    int unsigned seed_dummy;

    function automatic int nxt(int s);
        return (s + 1 == RING) ? 0 : s + 1;
    endfunction

    function automatic logic [255:0] exp_cmd(int s);
        return {bm[s*4+3], bm[s*4+2], bm[s*4+1], bm[s*4]};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic mem_word(input int idx, input logic [63:0] v);
        @(negedge clk);
        mem_we = 1; mem_addr = 10'(idx); mem_wdata = v;
        bm[idx] = v;
        @(negedge clk);
        mem_we = 0;
    endtask

    task automatic put_cmd(input int slot, input logic [7:0] op);
        for (int w = 0; w < 4; w++) begin
            logic [63:0] v;
            v = {$urandom(), $urandom()};
            if (w == 0) v[7:0] = op;
            mem_word(slot*4 + w, v);
        end
    endtask

    task automatic set_op(input int slot, input logic [7:0] op);
        logic [63:0] v;
        v = bm[slot*4];
        v[7:0] = op;
        mem_word(slot*4, v);
    endtask

    task automatic quiet_window(input int n, input string req);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (cmd_valid) seen++;
        end
        chk(seen == 0, req, 256'(seen), 256'(0));
    endtask

    task automatic serve(input bit ok, input bit co_en, input logic [63:0] co_val);
        int n = 0;
        int d;
        int old;
        logic [255:0] expd;
        while (!cmd_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        expd = exp_cmd(exp_rd);
        chk(cmd_valid, "R3", 256'(cmd_valid), 256'(1));
        chk(cmd_data == expd, "R3", cmd_data, expd);
        chk(!quiescent, "R10", 256'(quiescent), 256'(0));
        d = $urandom_range(0, 2);
        repeat (d) begin
            @(negedge clk);
            chk(cmd_valid && cmd_data == expd, "R3", cmd_data, expd);
        end
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        chk(!cmd_valid, "R3", 256'(cmd_valid), 256'(0));
        d = $urandom_range(0, 2);
        repeat (d) begin
            @(negedge clk);
            chk(rd_off == 13'(exp_rd*32), "R4", 256'(rd_off), 256'(exp_rd*32));
            chk(!quiescent, "R10", 256'(quiescent), 256'(0));
        end
        ret_valid = 1; ret_ok = ok;
        if (co_en) begin
            cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = co_val;
        end
        @(negedge clk);
        ret_valid = 0; ret_ok = 0; cfg_we = 0;
        old = exp_rd;
        if (ok) exp_rd = nxt(exp_rd);
        else    exp_stall = 1;
        if (co_en) exp_wr = int'(co_val[12:5]);
        if (ok && old == RING-1)
            chk(rd_off == 13'(exp_rd*32), "R5", 256'(rd_off), 256'(exp_rd*32));
        else if (ok)
            chk(rd_off == 13'(exp_rd*32), "R4", 256'(rd_off), 256'(exp_rd*32));
        else
            chk(rd_off == 13'(exp_rd*32), "R7", 256'(rd_off), 256'(exp_rd*32));
        chk(rd_off[4:0] == 5'd0, "R11", 256'(rd_off[4:0]), 256'(0));
        chk(stalled == exp_stall, "R7", 256'(stalled), 256'(exp_stall));
        chk(quiescent, "R10", 256'(quiescent), 256'(1));
        chk(empty == (exp_rd == exp_wr), "R6", 256'(empty), 256'(exp_rd == exp_wr));
        if (ok) served++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(rd_off == 0, "R1", 256'(rd_off), 256'(0));
        chk(!stalled && quiescent && empty && !cmd_valid, "R1",
            256'({stalled, quiescent, empty, cmd_valid}), 256'(4'b0110));
        chk(base_rd == 0, "R1", 256'(base_rd), 256'(0));

        // R2: enabled but base invalid
        cfg_write(2'd0, 64'd1);
        cfg_write(2'd1, 64'd0);
        put_cmd(0, 8'h03);
        cfg_write(2'd2, 64'd32);
        exp_wr = 1;
        quiet_window(12, "R2");
        chk(!empty, "R6", 256'(empty), 256'(0));

        // R11 attributes stored, R12 pointer at zero, then first command
        cfg_write(2'd1, BASEV);
        chk(base_rd == BASEV, "R11", 256'(base_rd), 256'(BASEV));
        chk(rd_off == 0, "R12", 256'(rd_off), 256'(0));
        serve(1, 0, 0);

        // R2: disabled unit does not fetch
        cfg_write(2'd0, 64'd0);
        put_cmd(1, 8'h0A);
        cfg_write(2'd2, 64'd64);
        exp_wr = 2;
        quiet_window(10, "R2");
        cfg_write(2'd0, 64'd1);
        serve(1, 0, 0);

        // random batches through the wrap point (R4, R5, R11)
        while (served < 150) begin
            int k;
            k = $urandom_range(1, 4);
            for (int i = 0; i < k; i++) begin
                put_cmd(exp_wr, 8'($urandom_range(1, 15)));
                exp_wr = nxt(exp_wr);
            end
            cfg_write(2'd2, 64'(exp_wr*32 + $urandom_range(0, 31)));
            for (int i = 0; i < k; i++) serve(1, 0, 0);
            quiet_window(3, "R6");
        end

        // R12: base write returns the read offset to zero
        cfg_write(2'd0, 64'd0);
        cfg_write(2'd1, BASEV);
        chk(rd_off == 0, "R12", 256'(rd_off), 256'(0));
        exp_rd = 0;
        cfg_write(2'd2, 64'd0);
        exp_wr = 0;
        cfg_write(2'd0, 64'd1);
        chk(empty, "R6", 256'(empty), 256'(1));
        quiet_window(5, "R6");

        // same-cycle: good retirement with write-offset update
        put_cmd(0, 8'h01);
        put_cmd(1, 8'h0F);
        cfg_write(2'd2, 64'd32);
        exp_wr = 1;
        serve(1, 1, 64'd64);
        serve(1, 0, 0);

        // same-cycle: failed retirement with write-offset update (R7, R9)
        put_cmd(2, 8'h05);
        put_cmd(3, 8'h06);
        cfg_write(2'd2, 64'd96);
        exp_wr = 3;
        serve(0, 1, 64'd128);
        quiet_window(10, "R9");
        chk(stalled, "R9", 256'(stalled), 256'(1));
        chk(rd_off == 13'd64, "R7", 256'(rd_off), 256'(64));
        cfg_write(2'd0, 64'd0);
        chk(stalled, "R9", 256'(stalled), 256'(1));
        cfg_write(2'd0, 64'd1);
        chk(!stalled, "R9", 256'(stalled), 256'(0));
        exp_stall = 0;
        serve(1, 0, 0);
        serve(1, 0, 0);

        // R8: opcode just above the accepted range
        put_cmd(4, 8'h10);
        cfg_write(2'd2, 64'd160);
        exp_wr = 5;
        quiet_window(10, "R8");
        chk(stalled, "R8", 256'(stalled), 256'(1));
        chk(rd_off == 13'd128, "R8", 256'(rd_off), 256'(128));
        chk(quiescent, "R10", 256'(quiescent), 256'(1));
        set_op(4, 8'h0F);
        cfg_write(2'd0, 64'd0);
        cfg_write(2'd0, 64'd1);
        exp_stall = 0;
        serve(1, 0, 0);

        // R8: opcode zero
        put_cmd(5, 8'h00);
        cfg_write(2'd2, 64'd192);
        exp_wr = 6;
        quiet_window(10, "R8");
        chk(stalled, "R8", 256'(stalled), 256'(1));
        chk(rd_off == 13'd160, "R8", 256'(rd_off), 256'(160));
        set_op(5, 8'h01);
        cfg_write(2'd0, 64'd0);
        cfg_write(2'd0, 64'd1);
        exp_stall = 0;
        serve(1, 0, 0);
        quiet_window(4, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule